// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a byte stream into a bit-oriented HDLC line signal. Each frame is wrapped in flag octets (01111110). A zero is inserted after any run of five ones in the frame content so that no flag can appear inside a frame. A frame check sequence follows the data, and it can be either 16 or 32 bits wide. When no frame is waiting, the line carries flags without a break. Between frames the block always sends at least a programmed number of flags.

Bytes arrive on a valid/ready interface, with a marker on the final byte of each frame. The line advances one bit for each cycle in which `bit_en` is high; `bit_en` is the strobe derived from the transmit clock. The serial bit appears on `tx_bit` and is qualified by `tx_vld`. If the byte source runs dry in the middle of a frame, the block aborts the frame on the line. It then goes back to sending flags.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst` is high, `tx_vld` and `in_ready` are low. After `rst` is released, the line begins with a complete flag.
- R2: Flag octet 0x7E is sent LSB first, which puts a 0 at each end. Flags are sent back to back whenever no frame is in progress, and no zero is ever inserted inside a flag.
- R3: Data bytes are sent LSB first. From the first data bit up to the last FCS bit, a 0 is inserted after every five consecutive ones. This includes a 0 that falls just before the closing flag.
- R4: A frame closes with one flag directly after the FCS (and after any inserted 0).
- R5: With `cfg_crc32`=0 the FCS is 16 bits. The polynomial is x^16+x^12+x^5+1. The register is preset to all ones and is fed with the data bits in line order. The ones complement of the register is sent with its highest-order bit first.
- R6: With `cfg_crc32`=1 the FCS is 32 bits and uses polynomial 0x04C11DB7, with the same preset, feed order, complement and bit order as in R5. The choice is sampled when the frame starts.
- R7: A frame starts only at the end of a flag, and only when that flag brings the count of flags since the last closing flag or abort to at least the programmed gap. The closing flag is counted as the first of these flags. The count starts from zero at reset.
- R8: A `cfg_gap` of 0 acts as 1, and a value above 62 acts as 62.
- R9: Suppose a data byte (not the last) finishes and no next byte is valid. The block then sends eight ones with no inserted 0, returns to flags, and restarts the flag count.
- R10: Each `bit_en` cycle yields exactly one line bit, shown on `tx_bit` with `tx_vld` high in the following cycle. `in_ready` is high only in the `bit_en` cycle in which a byte is taken, and it is never high when `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Line bit strobe: one bit per high cycle |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_data | input | DATA_W | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte is accepted this cycle |
| cfg_gap | input | GAP_W | Minimum flags between frames (1..62) |
| cfg_crc32 | input | 1 | 1 selects the 32-bit FCS, 0 the 16-bit FCS |
| tx_bit | output | 1 | Serial line bit |
| tx_vld | output | 1 | `tx_bit` holds a new bit this cycle |

## Verification
Every line bit shows up on `tx_bit` exactly one cycle after the `bit_en` cycle that produced it. `in_ready` is combinational, so it is due in the same cycle as the `bit_en` that consumes a byte. The reference model sits on the rising edge and reads inputs and `in_ready` at their pre-edge values, from which it computes that edge's expected bit and handshake. The registered `tx_bit`/`tx_vld` pair is then compared at the next falling edge, which makes every comparison exactly one register stage late, matching the design.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [1:0] {
    M_FLAG  = 2'd0,
    M_BODY  = 2'd1,
    M_FCS   = 2'd2,
    M_ABORT = 2'd3
  } tx_mode_e;

  localparam logic [7:0]  FLAG_OCTET = 8'h7E;
  localparam logic [15:0] POLY16     = 16'h1021;
  localparam logic [31:0] POLY32     = 32'h04C1_1DB7;
  localparam int          ABORT_LEN  = 8;
  localparam int          STUFF_RUN  = 5;
endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen
  import hdlc_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic upd,
  input  logic shift,
  input  logic din,
  input  logic wide,
  output logic fcs_bit
);
  logic [31:0] crc;
  logic        top;
  logic        fb;
  logic [31:0] poly;

  always_comb begin
    top     = wide ? crc[31] : crc[15];
    fb      = top ^ din;
    poly    = wide ? POLY32 : {16'h0000, POLY16};
    fcs_bit = ~top;
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc <= '1;
    end else if (upd) begin
      crc <= {crc[30:0], 1'b0} ^ (fb ? poly : 32'h0);
    end else if (shift) begin
      crc <= {crc[30:0], 1'b1};
    end
  end
endmodule

// File: rtl/hdlc_gap_count.sv
module hdlc_gap_count #(
  parameter int GAP_W   = 6,
  parameter int GAP_MAX = 62
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  input  logic [GAP_W-1:0] gap,
  output logic             met,
  output logic [GAP_W-1:0] cnt,
  output logic [GAP_W-1:0] eff
);
  localparam logic [GAP_W-1:0] CNT_MAX = {GAP_W{1'b1}};
  localparam logic [GAP_W-1:0] LIM     = GAP_W'(GAP_MAX);

  always_comb begin
    if (gap == '0)      eff = GAP_W'(1);
    else if (gap > LIM) eff = LIM;
    else                eff = gap;
    met = ({1'b0, cnt} + 1'b1) >= {1'b0, eff};
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GAP_W   = 6,
  parameter int GAP_MAX = 62
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              cfg_crc32,
  output logic              tx_bit,
  output logic              tx_vld
);
  localparam int SH_W   = (DATA_W > 8) ? DATA_W : 8;
  localparam int LEFT_W = 6;

  tx_mode_e          mode;
  logic [SH_W-1:0]   sh;
  logic [LEFT_W-1:0] left;
  logic [2:0]        ones;
  logic              crc32_q;
  logic              last_q;

  logic stuff, cur_bit, out_bit, unit_end;
  logic flag_done, start, byte_end, take_next, fcs_end, abort_end;
  logic gap_met, fcs_bit, in_frame;
  logic [GAP_W-1:0] flag_cnt, eff_gap;

  always_comb begin
    in_frame  = (mode == M_BODY) || (mode == M_FCS);
    stuff     = (mode != M_ABORT) && (ones == 3'(STUFF_RUN));
    case (mode)
      M_FCS:   cur_bit = fcs_bit;
      M_ABORT: cur_bit = 1'b1;
      default: cur_bit = sh[0];
    endcase
    out_bit   = stuff ? 1'b0 : cur_bit;
    unit_end  = bit_en && !stuff && (left == LEFT_W'(1));
    flag_done = unit_end && (mode == M_FLAG);
    start     = flag_done && gap_met && in_valid;
    byte_end  = unit_end && (mode == M_BODY);
    take_next = byte_end && !last_q && in_valid;
    fcs_end   = unit_end && (mode == M_FCS);
    abort_end = unit_end && (mode == M_ABORT);
    in_ready  = start || take_next;
  end

  hdlc_fcs_gen u_fcs (
    .clk     (clk),
    .rst     (rst),
    .init    (start),
    .upd     (bit_en && !stuff && (mode == M_BODY)),
    .shift   (bit_en && !stuff && (mode == M_FCS)),
    .din     (cur_bit),
    .wide    (crc32_q),
    .fcs_bit (fcs_bit)
  );

  hdlc_gap_count #(.GAP_W(GAP_W), .GAP_MAX(GAP_MAX)) u_gap (
    .clk (clk),
    .rst (rst),
    .inc (flag_done),
    .clr (start || fcs_end || abort_end),
    .gap (cfg_gap),
    .met (gap_met),
    .cnt (flag_cnt),
    .eff (eff_gap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= M_FLAG;
      sh      <= SH_W'(FLAG_OCTET);
      left    <= LEFT_W'(8);
      ones    <= '0;
      crc32_q <= 1'b0;
      last_q  <= 1'b0;
      tx_bit  <= 1'b0;
      tx_vld  <= 1'b0;
    end else begin
      tx_vld <= bit_en;
      if (bit_en) begin
        tx_bit <= out_bit;
        if (stuff || !in_frame) ones <= '0;
        else                    ones <= cur_bit ? ones + 1'b1 : 3'd0;
      end
      if (unit_end) begin
        case (mode)
          M_FLAG: begin
            if (start) begin
              mode    <= M_BODY;
              sh      <= SH_W'(in_data);
              left    <= LEFT_W'(DATA_W);
              last_q  <= in_last;
              crc32_q <= cfg_crc32;
            end else begin
              sh   <= SH_W'(FLAG_OCTET);
              left <= LEFT_W'(8);
            end
          end
          M_BODY: begin
            if (last_q) begin
              mode <= M_FCS;
              left <= crc32_q ? LEFT_W'(32) : LEFT_W'(16);
            end else if (in_valid) begin
              sh     <= SH_W'(in_data);
              left   <= LEFT_W'(DATA_W);
              last_q <= in_last;
            end else begin
              mode <= M_ABORT;
              left <= LEFT_W'(ABORT_LEN);
            end
          end
          default: begin
            mode <= M_FLAG;
            sh   <= SH_W'(FLAG_OCTET);
            left <= LEFT_W'(8);
          end
        endcase
      end else if (bit_en && !stuff) begin
        sh   <= sh >> 1;
        left <= left - 1'b1;
      end
    end
  end

  // Line-side observers for the properties below
  logic [3:0] out_run;
  logic [5:0] fcs_bits;
  always_ff @(posedge clk) begin
    if (rst) begin
      out_run  <= '0;
      fcs_bits <= '0;
    end else begin
      if (bit_en) out_run <= out_bit ? ((out_run == 4'hF) ? out_run : out_run + 1'b1) : 4'd0;
      if (mode == M_BODY) fcs_bits <= '0;
      else if (bit_en && !stuff && mode == M_FCS) fcs_bits <= fcs_bits + 1'b1;
    end
  end

  assert_vld_follows_en_R10: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> tx_vld);
  assert_vld_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> !tx_vld);
  assert_body_run_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == M_BODY || mode == M_FCS) |-> out_run <= 4'd5);
  assert_abort_len_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == M_FLAG && $past(mode) == M_ABORT) |-> out_run >= 4'd8);
  assert_fcs_len_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_FLAG && $past(mode) == M_FCS) |-> fcs_bits == (crc32_q ? 6'd32 : 6'd16));
  assert_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == M_BODY && $past(mode) == M_FLAG) |->
      ({1'b0, $past(flag_cnt)} + 1'b1) >= {1'b0, $past(eff_gap)});
endmodule

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;
  logic       clk = 1'b0;
  logic       rst;
  logic       bit_en;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       in_ready;
  logic [5:0] cfg_gap;
  logic       cfg_crc32;
  logic       tx_bit;
  logic       tx_vld;

  always #5 clk = ~clk;

  hdlc_tx_framer u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .cfg_gap(cfg_gap), .cfg_crc32(cfg_crc32),
    .tx_bit(tx_bit), .tx_vld(tx_vld)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int en_mode = 0;
  bit took = 0;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mq[$];
  int          m_mode;   // 0 flag, 1 data, 2 fcs, 3 abort
  int          m_ones, m_cnt;
  bit          m_last, m_w32;
  int unsigned m_crc;
  bit          pend_v, pend_b;
  string       pend_tag;

  task automatic push_flag();
    for (int k = 0; k < 8; k++) mq.push_back((8'h7E >> k) & 1);
  endtask

  task automatic m_load();
    for (int k = 0; k < 8; k++) mq.push_back(in_data[k]);
    m_last = in_last;
  endtask

  function automatic int unsigned crc_step(int unsigned c, bit b, bit w32);
    int unsigned poly = w32 ? 32'h04C11DB7 : 32'h1021;
    int w = w32 ? 32 : 16;
    bit fb = ((c >> (w - 1)) & 1) ^ b;
    c = c << 1;
    if (fb) c = c ^ poly;
    if (!w32) c = c & 32'hFFFF;
    return c;
  endfunction

  task automatic m_decide(output bit rdy);
    int g;
    rdy = 0;
    g = (cfg_gap == 0) ? 1 : ((cfg_gap > 62) ? 62 : int'(cfg_gap));   // R8
    case (m_mode)
      0: begin
        if (m_cnt < 63) m_cnt++;
        if (m_cnt >= g && in_valid) begin                               // R7
          m_load(); m_mode = 1; m_ones = 0; m_w32 = cfg_crc32;
          m_crc = m_w32 ? 32'hFFFFFFFF : 32'hFFFF; m_cnt = 0; rdy = 1;
        end else push_flag();
      end
      1: begin
        if (m_last) begin
          for (int k = (m_w32 ? 31 : 15); k >= 0; k--) mq.push_back(~m_crc[k]);
          m_mode = 2;
        end else if (in_valid) begin
          m_load(); rdy = 1;
        end else begin
          for (int k = 0; k < 8; k++) mq.push_back(1'b1);               // R9
          m_mode = 3;
        end
      end
      default: begin
        m_mode = 0; m_cnt = 0; push_flag();                             // R4
      end
    endcase
  endtask

  always @(posedge clk) begin
    bit eb, rdy;
    string tag;
    cyc++;
    took = in_valid && in_ready;
    if (rst) begin
      mq.delete(); push_flag();
      m_mode = 0; m_ones = 0; m_cnt = 0; m_last = 0; m_w32 = 0; m_crc = 0;
      pend_v = 0; pend_b = 0; pend_tag = "R1";
    end else begin
      rdy = 0;
      if (bit_en) begin
        if (m_mode != 3 && m_ones == 5) begin
          eb = 0; m_ones = 0; tag = "R3 stuff";
        end else begin
          case (m_mode)
            0: tag = "R2 R7 R8 flag";
            1: tag = "R3 data";
            2: tag = m_w32 ? "R6 fcs32" : "R5 fcs16";
            default: tag = "R9 abort";
          endcase
          eb = mq.pop_front();
          if (m_mode == 1 || m_mode == 2) m_ones = eb ? m_ones + 1 : 0;
          else m_ones = 0;
          if (m_mode == 1) m_crc = crc_step(m_crc, eb, m_w32);
          if (mq.size() == 0) m_decide(rdy);
        end
        pend_b = eb; pend_tag = tag;
      end
      pend_v = bit_en;
      chk(in_ready == rdy, "R10 in_ready", in_ready, rdy);
    end
    if (cyc >= 150000) begin
      chk(0, "R1 watchdog", cyc, 0);
      summary();
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      chk(!tx_vld && !in_ready, "R1 reset outputs", {tx_vld, in_ready}, 0);
    end else begin
      chk(tx_vld == pend_v, "R10 tx_vld", tx_vld, pend_v);
      if (pend_v) chk(tx_bit == pend_b, pend_tag, tx_bit, pend_b);
    end
  end

  // ---------------- stimulus ----------------
  always @(negedge clk) begin
    if (rst) bit_en = 0;
    else if (en_mode == 0) bit_en = 1;
    else bit_en = ($urandom % 3) != 0;
  end

  task automatic send_frame(input int n, input logic [7:0] seed, input int drop_at);
    for (int i = 0; i < n; i++) begin
      if (i == drop_at) begin
        in_valid = 0;                       // R9: starve the framer mid-frame
        repeat (300) @(negedge clk);
        return;
      end
      in_valid = 1;
      in_data  = seed ^ 8'(i * 8'h3B);
      in_last  = (i == n - 1);
      @(negedge clk);
      while (!took) @(negedge clk);
    end
    in_valid = 0;
    in_last  = 0;
  endtask

  initial begin
    rst = 1; in_valid = 0; in_data = 0; in_last = 0; cfg_gap = 1; cfg_crc32 = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (60) @(negedge clk);                   // R2 idle flags
    send_frame(4, 8'hFF, -1);                     // R3 R5 with long runs of ones
    send_frame(3, 8'h7E, -1);                     // R4 back to back, gap 1
    cfg_gap = 3;
    send_frame(5, 8'hF8, -1);                     // R7
    send_frame(2, 8'h01, -1);
    cfg_crc32 = 1;
    send_frame(6, 8'hFF, -1);                     // R6
    send_frame(1, 8'h1F, -1);
    cfg_gap = 0;
    send_frame(3, 8'hC3, -1);                     // R8 zero acts as one
    send_frame(2, 8'hFC, -1);
    cfg_gap = 63;
    send_frame(2, 8'h55, -1);                     // R8 clamp to 62
    send_frame(2, 8'hAA, -1);
    cfg_gap = 2; cfg_crc32 = 0;
    en_mode = 1;                                  // R10 gapped strobe
    send_frame(7, 8'hFF, -1);
    cfg_crc32 = 1;
    send_frame(4, 8'h3E, -1);
    send_frame(5, 8'hFF, 2);                      // R9 underrun after two bytes
    cfg_crc32 = 0;
    send_frame(3, 8'h0F, -1);
    en_mode = 0;
    send_frame(4, 8'hE7, 3);                      // R9 underrun, steady strobe
    send_frame(2, 8'h99, -1);
    repeat (800) @(negedge clk);
    summary();
  end
endmodule